// File: doc/BRIEF.md
# Test Access Port Controller with Scan-Chain Select

This block is a boundary-scan test access port controller clocked by the test clock `tck`. It has a 4-bit instruction register, a 1-bit bypass register, a 32-bit identification register and a 4-bit chain-select register. The chain-select register picks which internal scan chain the data path reaches. The chains themselves sit outside the block. For the selected chain only, the block gives a one-hot capture, shift and update strobe, and it forwards that chain's serial output to `tdo`. The testbench uses stubs in place of the real chains.

The controller is a sixteen-state machine that advances on the rising edge of `tck` and is steered by `tms`. The states are:

- Test-Logic-Reset (TLR) and Run-Test/Idle (RTI).
- On the data side: Select-DR, Capture-DR, Shift-DR, Exit1-DR, Pause-DR, Exit2-DR and Update-DR.
- On the instruction side: Select-IR, Capture-IR, Shift-IR, Exit1-IR, Pause-IR, Exit2-IR and Update-IR.

The transitions, written as "with `tms` high / with `tms` low", are:

| State | `tms` high | `tms` low |
|---|---|---|
| TLR | TLR | RTI |
| RTI | Select-DR | RTI |
| Select-DR | Select-IR | Capture-DR |
| Select-IR | TLR | Capture-IR |
| Capture-xR | Exit1-xR | Shift-xR |
| Shift-xR | Exit1-xR | Shift-xR |
| Exit1-xR | Update-xR | Pause-xR |
| Pause-xR | Exit2-xR | Pause-xR |
| Exit2-xR | Update-xR | Shift-xR |
| Update-xR | Select-DR | RTI |

Setting `trst_n` low forces TLR at any time, without waiting for a clock edge.

The instructions are:

| Code | Instruction | Effect |
|---|---|---|
| 0000 | EXTEST | Selected chain in test mode |
| 0010 | Chain select | Data path is the select register |
| 0011 | Sample/preload | Data path is the selected chain, not in test mode |
| 1110 | IDCODE | Data path is the identification register |
| 1111 | BYPASS | Data path is the 1-bit bypass register |

Every other code, including the usual internal-test code, acts as BYPASS.

Top module: `jtag_tap_chainsel`

## Requirements
- R1: Five consecutive rising edges of `tck` with `tms` high reach TLR from any state. A low `trst_n` forces TLR asynchronously.
- R2: TLR loads IDCODE (1110) into the instruction register. Capture-IR loads 0001, so the first bits out of Shift-IR are 1,0,0,0.
- R3: Under IDCODE, a 32-bit scan shifts out the value 32'h3B7AC0D3, least significant bit first. Bit 0 of this value is 1.
- R4: Under BYPASS (1111), the data path is one bit long and captures 0. Shifted data therefore appears on `tdo` one cycle late.
- R5: Codes not in the instruction table, such as 0101 and 0001, act exactly as BYPASS.
- R6: Under the chain-select code (0010), the data path is a 4-bit register that captures the current `chain_sel`. Update-DR copies the shifted code into `chain_sel`.
- R7: After a TAP reset, `chain_sel` is 0011, which selects the boundary chain.
- R8: `chain_sel` keeps its value through scans under any other instruction. It changes only on a chain-select update or a TAP reset.
- R9: EXTEST (0000) raises `extest_mode`. It also routes the data path to the selected chain, pulsing only that chain's bit of `chain_capture`, `chain_shift` and `chain_update`.
- R10: Sample/preload (0011) routes the data path to the selected chain in the same way, with `extest_mode` low.
- R11: `tdo_en` is high only while the state is Shift-IR or Shift-DR. `tdo` and `tdo_en` change only on the falling edge of `tck`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous test reset, active low |
| tms | input | 1 | Mode select that steers the state machine |
| tdi | input | 1 | Serial test data in |
| tdo | output | 1 | Serial test data out, updated on the falling edge |
| tdo_en | output | 1 | High while `tdo` carries shifted data |
| chain_so | input | 16 | Serial outputs of the internal chains, one bit per chain |
| chain_sel | output | 4 | Currently selected chain number |
| chain_capture | output | 16 | One-hot capture strobe for the selected chain |
| chain_shift | output | 16 | One-hot shift strobe for the selected chain |
| chain_update | output | 16 | One-hot update strobe for the selected chain |
| extest_mode | output | 1 | High while EXTEST is the active instruction |

## Verification
The data path is driven under each instruction with distinct bit patterns:

- IDCODE reads out a fixed constant. This separates a correct shift direction and capture value from a reversed or stuck register.
- BYPASS and two unlisted codes are given the same pattern. A one-cycle delay with a leading 0 tells a 1-bit path from a longer one, and from a decode that sends unknown codes elsewhere.
- Two chain stubs of different lengths and capture values are used: the boundary chain (8 bits) and chain 5 (6 bits). Which captured word comes back, and which stub counted strobes, shows whether the chain select was applied and held.
- A reset by five `tms`-high cycles is issued from the middle of Shift-DR. It is checked through `chain_sel` and an identification readback.
- `tdo` is sampled on both sides of each rising edge to expose changes on the wrong edge.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;

    typedef enum logic [3:0] {
        ST_TLR, ST_RTI,
        ST_SEL_DR, ST_CAP_DR, ST_SHF_DR, ST_EX1_DR, ST_PAU_DR, ST_EX2_DR, ST_UPD_DR,
        ST_SEL_IR, ST_CAP_IR, ST_SHF_IR, ST_EX1_IR, ST_PAU_IR, ST_EX2_IR, ST_UPD_IR
    } tap_state_t;

    localparam int IR_W = 4;
    typedef logic [IR_W-1:0] ir_t;

    localparam ir_t OP_EXTEST  = 4'b0000;
    localparam ir_t OP_CHSEL   = 4'b0010;
    localparam ir_t OP_SAMPLE  = 4'b0011;
    localparam ir_t OP_IDCODE  = 4'b1110;
    localparam ir_t OP_BYPASS  = 4'b1111;
    localparam ir_t IR_CAPTURE = 4'b0001;

endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tms,
    output tap_state_t state
);

    tap_state_t nxt;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) state <= ST_TLR;
        else         state <= nxt;
    end

    always_comb begin
        unique case (state)
            ST_TLR:    nxt = tms ? ST_TLR    : ST_RTI;
            ST_RTI:    nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_DR: nxt = tms ? ST_SEL_IR : ST_CAP_DR;
            ST_CAP_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_SHF_DR: nxt = tms ? ST_EX1_DR : ST_SHF_DR;
            ST_EX1_DR: nxt = tms ? ST_UPD_DR : ST_PAU_DR;
            ST_PAU_DR: nxt = tms ? ST_EX2_DR : ST_PAU_DR;
            ST_EX2_DR: nxt = tms ? ST_UPD_DR : ST_SHF_DR;
            ST_UPD_DR: nxt = tms ? ST_SEL_DR : ST_RTI;
            ST_SEL_IR: nxt = tms ? ST_TLR    : ST_CAP_IR;
            ST_CAP_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_SHF_IR: nxt = tms ? ST_EX1_IR : ST_SHF_IR;
            ST_EX1_IR: nxt = tms ? ST_UPD_IR : ST_PAU_IR;
            ST_PAU_IR: nxt = tms ? ST_EX2_IR : ST_PAU_IR;
            ST_EX2_IR: nxt = tms ? ST_UPD_IR : ST_SHF_IR;
            ST_UPD_IR: nxt = tms ? ST_SEL_DR : ST_RTI;
        endcase
    end

    AST_TLR_AFTER_FIVE: assert property (@(posedge tck) disable iff (!trst_n)
        (tms && $past(tms) && $past(tms, 2) && $past(tms, 3) && $past(tms, 4)) |=> state == ST_TLR) // R1
        else $error("five tms-high cycles did not reach reset");

endmodule

// File: rtl/tap_ir.sv
module tap_ir
    import jtag_tap_pkg::*;
(
    input  logic       tck,
    input  logic       trst_n,
    input  logic       tdi,
    input  tap_state_t state,
    output ir_t        ir,
    output logic       ir_so
);

    ir_t ir_sr;

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            ir    <= OP_IDCODE;
            ir_sr <= '0;
        end else begin
            case (state)
                ST_TLR:    ir    <= OP_IDCODE;
                ST_CAP_IR: ir_sr <= IR_CAPTURE;
                ST_SHF_IR: ir_sr <= {tdi, ir_sr[IR_W-1:1]};
                ST_UPD_IR: ir    <= ir_sr;
                default: ;
            endcase
        end
    end

    assign ir_so = ir_sr[0];

    AST_IR_RESET_IDCODE: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_TLR |=> ir == OP_IDCODE) // R2
        else $error("reset state did not load IDCODE");

    AST_IR_HELD: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_TLR && state != ST_UPD_IR) |=> $stable(ir)) // R2
        else $error("instruction changed outside update");

endmodule

// File: rtl/tap_dr.sv
module tap_dr
    import jtag_tap_pkg::*;
#(
    parameter int           SEL_W          = 4,
    parameter int           ID_W           = 32,
    parameter logic [ID_W-1:0] IDCODE_VAL  = 32'h3B7A_C0D3,
    parameter int           BOUNDARY_CHAIN = 3
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  tap_state_t       state,
    input  ir_t              ir,
    output logic [SEL_W-1:0] chain_sel,
    output logic             dr_so
);

    localparam logic [SEL_W-1:0] SEL_RST = SEL_W'(BOUNDARY_CHAIN);

    logic             bypass_q;
    logic [ID_W-1:0]  id_sr;
    logic [SEL_W-1:0] sel_sr;
    logic             is_id, is_sel;

    assign is_id  = (ir == OP_IDCODE);
    assign is_sel = (ir == OP_CHSEL);

    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n) begin
            bypass_q  <= 1'b0;
            id_sr     <= '0;
            sel_sr    <= '0;
            chain_sel <= SEL_RST;
        end else begin
            case (state)
                ST_TLR: chain_sel <= SEL_RST;
                ST_CAP_DR: begin
                    bypass_q <= 1'b0;
                    if (is_id)  id_sr  <= IDCODE_VAL;
                    if (is_sel) sel_sr <= chain_sel;
                end
                ST_SHF_DR: begin
                    bypass_q <= tdi;
                    if (is_id)  id_sr  <= {tdi, id_sr[ID_W-1:1]};
                    if (is_sel) sel_sr <= {tdi, sel_sr[SEL_W-1:1]};
                end
                ST_UPD_DR: if (is_sel) chain_sel <= sel_sr;
                default: ;
            endcase
        end
    end

    assign dr_so = is_id ? id_sr[0] : (is_sel ? sel_sr[0] : bypass_q);

    AST_SEL_RESET: assert property (@(posedge tck) disable iff (!trst_n)
        state == ST_TLR |=> chain_sel == SEL_RST) // R7
        else $error("chain select not restored on reset");

    AST_SEL_HELD: assert property (@(posedge tck) disable iff (!trst_n)
        (state != ST_TLR && !(state == ST_UPD_DR && ir == OP_CHSEL)) |=> $stable(chain_sel)) // R8
        else $error("chain select changed without a select update");

endmodule

// File: rtl/jtag_tap_chainsel.sv
module jtag_tap_chainsel
    import jtag_tap_pkg::*;
#(
    parameter int              SEL_W          = 4,
    parameter int              ID_W           = 32,
    parameter logic [ID_W-1:0] IDCODE_VAL     = 32'h3B7A_C0D3,
    parameter int              BOUNDARY_CHAIN = 3,
    localparam int             NUM_CHAINS     = 1 << SEL_W
) (
    input  logic                  tck,
    input  logic                  trst_n,
    input  logic                  tms,
    input  logic                  tdi,
    output logic                  tdo,
    output logic                  tdo_en,
    input  logic [NUM_CHAINS-1:0] chain_so,
    output logic [SEL_W-1:0]      chain_sel,
    output logic [NUM_CHAINS-1:0] chain_capture,
    output logic [NUM_CHAINS-1:0] chain_shift,
    output logic [NUM_CHAINS-1:0] chain_update,
    output logic                  extest_mode
);

    tap_state_t state;
    ir_t        ir;
    logic       ir_so, dr_so, chain_path, shf_ir, shf_dr;

    tap_fsm u_fsm (
        .tck    (tck),
        .trst_n (trst_n),
        .tms    (tms),
        .state  (state)
    );

    tap_ir u_ir (
        .tck    (tck),
        .trst_n (trst_n),
        .tdi    (tdi),
        .state  (state),
        .ir     (ir),
        .ir_so  (ir_so)
    );

    tap_dr #(
        .SEL_W          (SEL_W),
        .ID_W           (ID_W),
        .IDCODE_VAL     (IDCODE_VAL),
        .BOUNDARY_CHAIN (BOUNDARY_CHAIN)
    ) u_dr (
        .tck       (tck),
        .trst_n    (trst_n),
        .tdi       (tdi),
        .state     (state),
        .ir        (ir),
        .chain_sel (chain_sel),
        .dr_so     (dr_so)
    );

    assign chain_path  = (ir == OP_EXTEST) || (ir == OP_SAMPLE);
    assign extest_mode = (ir == OP_EXTEST);
    assign shf_ir      = (state == ST_SHF_IR);
    assign shf_dr      = (state == ST_SHF_DR);

    for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_strobe
        logic hit;
        assign hit              = chain_path && (chain_sel == SEL_W'(c));
        assign chain_capture[c] = hit && (state == ST_CAP_DR);
        assign chain_shift[c]   = hit && shf_dr;
        assign chain_update[c]  = hit && (state == ST_UPD_DR);
    end

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_en <= 1'b0;
        end else begin
            tdo_en <= shf_ir || shf_dr;
            if (shf_ir)      tdo <= ir_so;
            else if (shf_dr) tdo <= chain_path ? chain_so[chain_sel] : dr_so;
            else             tdo <= 1'b0;
        end
    end

    AST_STROBE_ONEHOT: assert property (@(posedge tck) disable iff (!trst_n)
        $onehot0(chain_shift) && $onehot0(chain_capture) && $onehot0(chain_update)) // R9
        else $error("more than one chain strobed");

    AST_TDO_EN_WINDOW: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_en == (shf_ir || shf_dr)) // R11
        else $error("tdo enable outside a shift state");

    AST_NO_CHAIN_STROBE: assert property (@(posedge tck) disable iff (!trst_n)
        !chain_path |-> (chain_shift == '0)) // R10
        else $error("chain shifted under a non-chain instruction");

endmodule

// File: tb/jtag_tap_chainsel_tb.sv
`timescale 1ns/100ps
module jtag_tap_chainsel_tb;

    localparam logic [31:0] ID_EXP = 32'h3B7A_C0D3;

    logic        tck = 1'b0;
    logic        trst_n = 1'b0;
    logic        tms = 1'b1;
    logic        tdi = 1'b0;
    logic        tdo, tdo_en, extest_mode;
    logic [15:0] chain_so, chain_capture, chain_shift, chain_update;
    logic [3:0]  chain_sel;

    int n_chk = 0;
    int n_fail = 0;
    int glitch = 0;
    int en_miss = 0;
    bit done = 0;

    always #2 tck = ~tck;

    jtag_tap_chainsel u_dut (
        .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo), .tdo_en(tdo_en),
        .chain_so(chain_so), .chain_sel(chain_sel), .chain_capture(chain_capture),
        .chain_shift(chain_shift), .chain_update(chain_update), .extest_mode(extest_mode)
    );

    // chain stubs: boundary chain 3 (8 bits), chain 5 (6 bits)
    logic [7:0] bnd_q = '0;
    logic [7:0] bnd_latch = '0;
    logic [5:0] c5_q = '0;
    int sh3 = 0, sh5 = 0, sh_other = 0, up3 = 0;

    always @(posedge tck) begin
        if (chain_capture[3]) bnd_q <= 8'hA5;
        else if (chain_shift[3]) bnd_q <= {tdi, bnd_q[7:1]};
        if (chain_update[3]) begin
            bnd_latch <= bnd_q;
            up3 <= up3 + 1;
        end
        if (chain_capture[5]) c5_q <= 6'h2D;
        else if (chain_shift[5]) c5_q <= {tdi, c5_q[5:1]};
        if (chain_shift[3]) sh3 <= sh3 + 1;
        if (chain_shift[5]) sh5 <= sh5 + 1;
        if ((chain_shift & ~16'h0028) != 16'h0) sh_other <= sh_other + 1;
    end

    always_comb begin
        chain_so    = '0;
        chain_so[3] = bnd_q[0];
        chain_so[5] = c5_q[0];
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input logic m, input logic d, output logic o, output logic oe);
        @(negedge tck);
        #1;
        tms = m;
        tdi = d;
        o  = tdo;
        oe = tdo_en;
        @(posedge tck);
        #0.5;
        if (tdo !== o) glitch++;
    endtask

    task automatic go_idle();
        logic o, oe;
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
    endtask

    task automatic shift_ir(input logic [3:0] code, output logic [3:0] dout);
        logic o, oe;
        tick(1'b1, 1'b0, o, oe);
        tick(1'b1, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
        for (int i = 0; i < 4; i++) begin
            tick(i == 3, code[i], o, oe);
            dout[i] = o;
            if (!oe) en_miss++;
        end
        tick(1'b1, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
    endtask

    task automatic shift_dr(input int n, input logic [63:0] din, output logic [63:0] dout);
        logic o, oe;
        dout = '0;
        tick(1'b1, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
        for (int i = 0; i < n; i++) begin
            tick(i == n - 1, din[i], o, oe);
            dout[i] = o;
            if (!oe) en_miss++;
        end
        tick(1'b1, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
    endtask

    task automatic t_reset();
        logic [63:0] d;
        #5 trst_n = 1'b1;
        go_idle();
        check("R7 chain_sel after reset", chain_sel, 4'b0011);
        check("R11 tdo_en idle", tdo_en, 1'b0);
        shift_dr(32, 64'h0, d);
        check("R2 reset instruction is IDCODE", d[31:0], ID_EXP);
    endtask

    task automatic t_idcode();
        logic [3:0]  c;
        logic [63:0] d;
        shift_ir(4'b1110, c);
        check("R2 capture-IR pattern", c, 4'b0001);
        shift_dr(32, 64'h5555_5555, d);
        check("R3 idcode readout", d[31:0], ID_EXP);
        check("R3 idcode lsb", d[0], 1'b1);
    endtask

    task automatic t_bypass(input logic [3:0] code, input string req);
        logic [3:0]  c;
        logic [63:0] d;
        shift_ir(code, c);
        shift_dr(9, 64'h16D, d);
        check(req, d[8:0], {8'h6D, 1'b0});
    endtask

    task automatic t_chsel();
        logic [3:0]  c;
        logic [63:0] d;
        shift_ir(4'b0010, c);
        shift_dr(4, 64'h5, d);
        check("R6 select captures current", d[3:0], 4'b0011);
        check("R6 select updated", chain_sel, 4'b0101);
        shift_dr(4, 64'h5, d);
        check("R6 select recapture", d[3:0], 4'b0101);
    endtask

    task automatic t_hold();
        logic [3:0]  c;
        logic [63:0] d;
        shift_ir(4'b1111, c);
        shift_dr(4, 64'hA, d);
        check("R8 select held under bypass", chain_sel, 4'b0101);
        shift_ir(4'b1110, c);
        shift_dr(32, 64'h0, d);
        check("R8 select held under idcode", chain_sel, 4'b0101);
    endtask

    task automatic t_sample();
        logic [3:0]  c;
        logic [63:0] d;
        int s5, s3, so;
        shift_ir(4'b0011, c);
        check("R10 extest_mode low", extest_mode, 1'b0);
        s5 = sh5; s3 = sh3; so = sh_other;
        shift_dr(6, 64'h12, d);
        check("R10 chain 5 capture readout", d[5:0], 6'h2D);
        check("R10 chain 5 shift count", sh5 - s5, 6);
        check("R10 other chains idle", (sh3 - s3) + (sh_other - so), 0);
    endtask

    task automatic t_extest();
        logic [3:0]  c;
        logic [63:0] d;
        int s3, s5, so, u3;
        shift_ir(4'b0010, c);
        shift_dr(4, 64'h3, d);
        shift_ir(4'b0000, c);
        check("R9 extest_mode high", extest_mode, 1'b1);
        s3 = sh3; s5 = sh5; so = sh_other; u3 = up3;
        shift_dr(8, 64'h3C, d);
        check("R9 boundary capture readout", d[7:0], 8'hA5);
        check("R9 boundary update pulse", up3 - u3, 1);
        check("R9 boundary latched data", bnd_latch, 8'h3C);
        check("R9 only boundary shifted", {(sh3 - s3), (sh5 - s5) + (sh_other - so)}, {32'd8, 32'd0});
    endtask

    task automatic t_tlr5();
        logic [3:0]  c;
        logic [63:0] d;
        logic o, oe;
        shift_ir(4'b0010, c);
        shift_dr(4, 64'h5, d);
        check("R1 precondition select", chain_sel, 4'b0101);
        tick(1'b1, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
        tick(1'b0, 1'b1, o, oe);
        tick(1'b0, 1'b0, o, oe);
        for (int i = 0; i < 5; i++) tick(1'b1, 1'b0, o, oe);
        tick(1'b0, 1'b0, o, oe);
        check("R1 five tms reset select", chain_sel, 4'b0011);
        shift_dr(32, 64'h0, d);
        check("R1 five tms reset instruction", d[31:0], ID_EXP);
        trst_n = 1'b0;
        #1;
        check("R1 async trst select", chain_sel, 4'b0011);
        check("R11 tdo_en in reset", tdo_en, 1'b0);
        #3 trst_n = 1'b1;
        go_idle();
    endtask

    task automatic t_edges();
        check("R11 tdo only on falling edge", glitch, 0);
        check("R11 tdo_en during shifts", en_miss, 0);
        check("R11 tdo_en low in idle", tdo_en, 1'b0);
    endtask

    initial begin
        t_reset();
        t_idcode();
        t_bypass(4'b1111, "R4 bypass delay");
        t_bypass(4'b0101, "R5 unused code 0101 as bypass");
        t_bypass(4'b0001, "R5 unused code 0001 as bypass");
        t_chsel();
        t_hold();
        t_sample();
        t_extest();
        t_tlr5();
        t_edges();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge tck);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule